// File: doc/BRIEF.md
# Programmable Two-Digit Divide-by-N Down Counter

The block divides its clock by a programmable ratio N. It keeps a count made of two 4-bit digits that counts down. An 8-bit preset supplies N. The low nibble feeds the lower digit and the high nibble feeds the upper digit. A per-digit mode bit chooses decimal (0 to 9) or binary (0 to 15) counting for that digit, so one counter can divide by mixed-radix ratios. When the lower digit underflows, it borrows from the upper one.

While the cascade enable is high, the count goes back to the preset on the edge after it reaches one. The zero-detect output then gives a one-cycle pulse every N clocks. While the cascade enable is low, the preset is ignored and the count runs down through zero and wraps. This lets a following stage control the division. The output `q` shows the top bit of the upper digit.

Top module: `ndiv_counter`

## Requirements
- R1: While `rst` is high, each rising edge loads `preset` into the count and forces `zero_det` low. On the first cycle after release, `q` equals `preset[7]`.
- R2: `bcd_mode[0]` sets the mode of the lower digit and `bcd_mode[1]` sets the mode of the upper digit. A value of 1 means decimal, where the digit wraps from 0 to 9. A value of 0 means binary, where the digit wraps from 0 to 15. When the lower digit wraps, it takes one from the upper digit.
- R3: While `cas_fb` is high, a count of one is replaced by `preset` on the next edge. Take h and l as the preset nibbles and L as 10 (lower digit decimal) or 16 (lower digit binary). Then v = h*L + l. For v of 2 or more, the spacing between `zero_det` pulses is v clocks, and the first pulse comes v edges after reset release.
- R4: `zero_det` is high for exactly the one cycle after each edge at which the count was one, and low otherwise. For ratios of 2 or more, each pulse is one cycle wide.
- R5: A preset with v = 1 cannot give a divide-by-one pulse train. `zero_det` then stays high on every cycle.
- R6: A preset of zero makes the count wrap through the full range. The period is then the product of the two digit moduli (100, 160 or 256).
- R7: A digit above 9 in decimal mode counts down by one per borrow until it reaches 0, then wraps to 9. The period formula of R3 still applies with that digit's raw value.
- R8: While `cas_fb` is low, `preset` has no effect. The count passes through zero and wraps, `zero_det` still pulses after the count was one, and the pulse spacing equals the product of the digit moduli.
- R9: `q` is bit 3 of the upper digit. While `cas_fb` is high and the preset is nonzero, `q` stays low whenever `preset[7]` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count steps on each rising edge |
| rst | input | 1 | Synchronous active-high reset; loads the preset |
| preset | input | 8 | Ratio N; bits 3..0 lower digit, bits 7..4 upper digit |
| bcd_mode | input | 2 | Per-digit mode; bit 0 lower, bit 1 upper; 1 = decimal |
| cas_fb | input | 1 | High enables reload; low ignores preset and free-runs |
| zero_det | output | 1 | One-cycle terminal-count pulse |
| q | output | 1 | Most significant bit of the upper digit |

## Verification
The properties assume that the mode and preset inputs hold known values on every sampled edge. The decimal-range property also assumes that the lower digit has already entered 0..9 before it is checked. The bench holds mode, preset and cascade enable fixed within each measured period, with one exception: in the free-run phase it changes the preset on every cycle so that R8 is tested. Every mode pair is swept across a stepped set of presets, including out-of-range decimal digits, zero and one. The measured spacings are compared with h*L + l or with the full modulus, both computed in the bench.

// File: rtl/ndiv_pkg.sv
package ndiv_pkg;
    localparam int NIB = 4;

    typedef logic [NIB-1:0] nib_t;

    typedef struct packed {
        nib_t val;
        logic borrow;
    } dec_res_t;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_RELOAD = 2'd1,
        ST_WRAP   = 2'd2
    } step_e;

    // Decrement one digit when a borrow arrives; wrap at zero per mode.
    function automatic dec_res_t nib_dec(nib_t cur, logic bcd, logic take);
        dec_res_t r;
        if (!take) begin
            r.val    = cur;
            r.borrow = 1'b0;
        end else if (cur == '0) begin
            r.val    = bcd ? nib_t'(9) : nib_t'(15);
            r.borrow = 1'b1;
        end else begin
            r.val    = cur - nib_t'(1);
            r.borrow = 1'b0;
        end
        return r;
    endfunction
endpackage

// File: rtl/ndiv_digit.sv
module ndiv_digit
    import ndiv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  step_e step,
    input  logic  bcd,
    input  logic  borrow_in,
    input  nib_t  preset_nib,
    output nib_t  cur,
    output logic  borrow_out
);
    dec_res_t res;

    always_comb begin
        res        = nib_dec(cur, bcd, borrow_in);
        borrow_out = res.borrow;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= preset_nib;
        end else if (step == ST_RELOAD) begin
            cur <= preset_nib;
        end else begin
            cur <= res.val;
        end
    end
endmodule

// File: rtl/ndiv_term.sv
module ndiv_term #(
    parameter int PW = 8
) (
    input  logic [PW-1:0] count,
    output logic          at_one
);
    always_comb at_one = (count == PW'(1));
endmodule

// File: rtl/ndiv_counter.sv
module ndiv_counter
    import ndiv_pkg::*;
#(
    parameter int DIGITS = 2,
    localparam int PW = DIGITS * NIB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PW-1:0]     preset,
    input  logic [DIGITS-1:0] bcd_mode,
    input  logic              cas_fb,
    output logic              zero_det,
    output logic              q
);
    logic [PW-1:0]   count;
    logic [DIGITS:0] borrow;
    logic            at_one;
    step_e           step;

    assign borrow[0] = 1'b1;

    genvar g;
    generate
        for (g = 0; g < DIGITS; g++) begin : g_dig
            ndiv_digit u_dig (
                .clk        (clk),
                .rst        (rst),
                .step       (step),
                .bcd        (bcd_mode[g]),
                .borrow_in  (borrow[g]),
                .preset_nib (preset[g*NIB +: NIB]),
                .cur        (count[g*NIB +: NIB]),
                .borrow_out (borrow[g+1])
            );
        end
    endgenerate

    ndiv_term #(.PW(PW)) u_term (
        .count  (count),
        .at_one (at_one)
    );

    always_comb begin
        if (!at_one) begin
            step = ST_RUN;
        end else if (cas_fb) begin
            step = ST_RELOAD;
        end else begin
            step = ST_WRAP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            zero_det <= 1'b0;
        end else begin
            zero_det <= at_one;
        end
    end

    assign q = count[PW-1];
endmodule

// File: rtl/ndiv_checker.sv
module ndiv_checker #(
    parameter int PW = 8,
    parameter int DIGITS = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [PW-1:0]     preset,
    input logic [DIGITS-1:0] bcd_mode,
    input logic              cas_fb,
    input logic              zero_det,
    input logic [PW-1:0]     count
);
    p_reset_load_r1: assert property (@(posedge clk)
        rst |=> (!zero_det && count == $past(preset)));

    p_reload_r3: assert property (@(posedge clk) disable iff (rst)
        (cas_fb && count == PW'(1)) |=> (count == $past(preset)));

    p_wrap_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (!cas_fb && count == PW'(1)) |=> (count == '0));

    p_pulse_hi_r4: assert property (@(posedge clk) disable iff (rst)
        (count == PW'(1)) |=> zero_det);

    p_pulse_lo_r4: assert property (@(posedge clk) disable iff (rst)
        (count != PW'(1)) |=> !zero_det);

    p_bcd_range_r2: assert property (@(posedge clk) disable iff (rst)
        (bcd_mode[0] && count[3:0] <= 4'd9 && count != PW'(1)) |=> (count[3:0] <= 4'd9));
endmodule

bind ndiv_counter ndiv_checker #(.PW(PW), .DIGITS(DIGITS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .preset   (preset),
    .bcd_mode (bcd_mode),
    .cas_fb   (cas_fb),
    .zero_det (zero_det),
    .count    (count)
);

// File: tb/tb_ndiv_counter.sv
module tb_ndiv_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] preset = 8'd0;
    logic [1:0] bcd_mode = 2'b00;
    logic       cas_fb = 1'b1;
    logic       zero_det;
    logic       q;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    ndiv_counter dut (
        .clk      (clk),
        .rst      (rst),
        .preset   (preset),
        .bcd_mode (bcd_mode),
        .cas_fb   (cas_fb),
        .zero_det (zero_det),
        .q        (q)
    );

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (preset=%02h mode=%0d fb=%0d)",
                     tag, act, exp, preset, bcd_mode, cas_fb);
        end
    endtask

    function automatic int modulus(input logic [1:0] m);
        return (m[1] ? 10 : 16) * (m[0] ? 10 : 16);
    endfunction

    function automatic int period_of(input logic [7:0] p, input logic [1:0] m);
        int v;
        v = int'(p[7:4]) * (m[0] ? 10 : 16) + int'(p[3:0]);
        return (v == 0) ? modulus(m) : v;
    endfunction

    task automatic step1();
        @(posedge clk);
        #1;
    endtask

    // Edges until zero_det is seen high; optionally scramble preset each cycle.
    task automatic edges_to_pulse(input bit scramble, input bit qwatch, output int n, output bit qbad);
        n = 0;
        qbad = 1'b0;
        do begin
            if (scramble) preset = preset * 8'd37 + 8'd11;
            step1();
            n++;
            if (qwatch && q) qbad = 1'b1;
        end while (!zero_det && n < 400);
    endtask

    task automatic run_preset(input logic [7:0] p, input logic [1:0] m);
        int exp, n1, n2;
        bit qb1, qb2, qwatch;
        exp = period_of(p, m);
        qwatch = (p[7] == 1'b0) && (p != 8'd0);
        rst = 1'b1; preset = p; bcd_mode = m; cas_fb = 1'b1;
        step1();
        step1();
        rst = 1'b0;
        check("R1 zero_det low after reset", int'(zero_det), 0);
        check("R1 q equals preset bit 7", int'(q), int'(p[7]));
        edges_to_pulse(1'b0, qwatch, n1, qb1);
        check((p == 8'd0) ? "R6 first pulse latency" : "R3/R7 first pulse latency", n1, exp);
        if (exp >= 2) begin
            step1();
            check("R4 pulse width one cycle", int'(zero_det), 0);
            edges_to_pulse(1'b0, qwatch, n2, qb2);
            n2++;
            check((p == 8'd0) ? "R6 pulse spacing" : "R3/R2 pulse spacing", n2, exp);
        end else begin
            step1();
            check("R5 zero_det held high", int'(zero_det), 1);
            step1();
            check("R5 zero_det held high", int'(zero_det), 1);
            qb2 = 1'b0;
        end
        if (qwatch) check("R9 q low with preset bit 7 low", int'(qb1 | qb2), 0);
    endtask

    task automatic run_cascade(input logic [7:0] p, input logic [1:0] m);
        int n1, n2;
        bit qb;
        rst = 1'b1; preset = p; bcd_mode = m; cas_fb = 1'b0;
        step1();
        rst = 1'b0;
        edges_to_pulse(1'b1, 1'b0, n1, qb);
        check("R8 first pulse from loaded value", n1, period_of(p, m));
        edges_to_pulse(1'b1, 1'b0, n2, qb);
        check("R8 free-run spacing ignores preset", n2, modulus(m));
        edges_to_pulse(1'b1, 1'b0, n2, qb);
        check("R8 free-run spacing repeat", n2, modulus(m));
    endtask

    initial begin
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 256; p += 3) begin
                run_preset(8'(p), 2'(m));
            end
            run_preset(8'h01, 2'(m));
            run_preset(8'h02, 2'(m));
            run_preset(8'h99, 2'(m));
            run_preset(8'hFF, 2'(m));
            run_preset(8'h0C, 2'(m));
            run_preset(8'hA3, 2'(m));
            run_cascade(8'h25, 2'(m));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (190000) @(posedge clk);
                errors++;
                vectors++;
                $display("FAIL watchdog expired actual=running expected=finished");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule